// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Alarm

This block is a real-time clock peripheral on a simple 32-bit register bus. A slow-clock enable (`slow_tick`) is divided down to a one-second tick. While counting is enabled, each tick advances a free-running 32-bit seconds counter. A 32-bit alarm value is compared against that counter. A control/status word holds the enables, two event flags, the two interrupt enables and a write-ready indication. Two further registers are a hibernate request and a scratchpad whose contents survive the block reset.

Register writes do not take effect at once. They are accepted into a single-entry write path. That path commits them only after a set number of slow ticks, which models the latency of a slow power domain. Software must wait for the ready bit before it issues a write. Reads return the current state in the same cycle.

The two event flags can be cleared only by writing 0 to them, and writing 1 leaves them as they are. A read-modify-write that forces both flag bits to 1 therefore never loses an event. One level interrupt output combines each flag with its enable. A committed hibernate request gives a single-cycle pulse.

Top module: `sec_rtc`

## Requirements
- R1: Register offsets on `bus_addr` are: control 0x00, seconds 0x04, alarm 0x08, hibernate 0x20 and scratchpad 0x34. Any other offset reads 0, and a write to it changes nothing. After reset, control reads 0x0000_0080 (bit 7 ready=1, every other bit 0), seconds reads 0, and `irq_o` and `hib_o` are 0.
- R2: A write presented while control bit 7 is 1 is accepted at that clock edge. Bit 7 reads 0 from the next cycle. The write commits on the WR_LAT-th following `slow_tick`, and bit 7 reads 1 again after the commit. The written value is readable once bit 7 has returned to 1.
- R3: A write presented while control bit 7 is 0 is dropped and changes no register.
- R4: The writable control bits are: bit 0 count enable, bit 2 alarm enable, bit 3 alarm interrupt enable and bit 5 one-second interrupt enable. Bit 7 (ready) is read-only.
- R5: Control bit 6 (one-second flag) and bit 4 (alarm flag) are kept when written 1 and cleared when written 0. A set event in the same cycle takes priority over the clear.
- R6: While bit 0 is 1, seconds increments once every DIV slow ticks, wrapping from 0xFFFF_FFFF to 0, and each increment sets bit 6. While bit 0 is 0, seconds holds its value and the prescaler restarts.
- R7: While bit 2 is 1 and seconds equals the alarm register, bit 4 becomes set. While bit 2 is 0, no match sets it.
- R8: `irq_o` is 1 exactly when (bit 6 and bit 5) or (bit 4 and bit 3) are both set.
- R9: A committed write to the hibernate offset with data bit 0 = 1 gives exactly one single-cycle pulse on `hib_o`. With data bit 0 = 0 it gives none.
- R10: The scratchpad reads back the last committed 32-bit value and keeps it through `rst`.
- R11: A committed seconds write takes priority over a simultaneous increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | One-cycle enable per slow-clock period |
| bus_addr | input | 6 | Register byte offset for reads and writes |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |
| irq_o | output | 1 | Level interrupt |
| hib_o | output | 1 | Hibernate request pulse |

## Verification
The bench builds the block with DIV=4 and WR_LAT=2, and drives `slow_tick` every second clock. One second is therefore eight clocks and a write stays busy for a few clocks. With these values the bench can reach an alarm match after a couple of counted seconds, the wrap from all-ones, and several one-second flag sets within a few hundred cycles. The busy window is long enough for a deliberately dropped write to land inside it. The flag-preserving and flag-clearing writes are issued with the counter stopped, so every expected control value is exact.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int RTC_AW = 6;
    localparam int RTC_DW = 32;

    localparam logic [RTC_AW-1:0] OFF_CTRL  = 6'h00;
    localparam logic [RTC_AW-1:0] OFF_SECS  = 6'h04;
    localparam logic [RTC_AW-1:0] OFF_ALARM = 6'h08;
    localparam logic [RTC_AW-1:0] OFF_HIB   = 6'h20;
    localparam logic [RTC_AW-1:0] OFF_SCR   = 6'h34;

    localparam int B_RDY  = 7;
    localparam int B_HZ   = 6;
    localparam int B_HZIE = 5;
    localparam int B_AF   = 4;
    localparam int B_AFIE = 3;
    localparam int B_AE   = 2;
    localparam int B_EN   = 0;

    typedef struct packed {
        logic en;
        logic ae;
        logic af_ie;
        logic af;
        logic hz_ie;
        logic hz;
    } ctrl_t;

    typedef struct packed {
        logic [RTC_AW-1:0] addr;
        logic [RTC_DW-1:0] data;
    } wr_req_t;

    function automatic ctrl_t merge_ctrl(ctrl_t cur, logic [RTC_DW-1:0] w);
        ctrl_t n;
        n.en    = w[B_EN];
        n.ae    = w[B_AE];
        n.af_ie = w[B_AFIE];
        n.hz_ie = w[B_HZIE];
        n.af    = cur.af & w[B_AF];
        n.hz    = cur.hz & w[B_HZ];
        return n;
    endfunction

    function automatic logic [RTC_DW-1:0] pack_ctrl(ctrl_t c, logic rdy);
        logic [RTC_DW-1:0] v;
        v         = '0;
        v[B_RDY]  = rdy;
        v[B_HZ]   = c.hz;
        v[B_HZIE] = c.hz_ie;
        v[B_AF]   = c.af;
        v[B_AFIE] = c.af_ie;
        v[B_AE]   = c.ae;
        v[B_EN]   = c.en;
        return v;
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int DIV = 32768
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic slow_tick,
    output logic sec_tick
);
    generate
        if (DIV <= 1) begin : g_direct
            assign sec_tick = run && slow_tick;
        end else begin : g_count
            localparam int CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] cnt;

            assign sec_tick = run && slow_tick && (cnt == LAST);

            always_ff @(posedge clk) begin
                if (rst || !run) begin
                    cnt <= '0;
                end else if (slow_tick) begin
                    cnt <= (cnt == LAST) ? '0 : cnt + CW'(1);
                end
            end

            AST_PRESCALE_IDLE: assert property (@(posedge clk) disable iff (rst)
                !run |=> cnt == '0); // R6
        end
    endgenerate
endmodule

// File: rtl/rtc_wr_pipe.sv
module rtc_wr_pipe
    import rtc_pkg::*;
#(
    parameter int LAT = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    slow_tick,
    input  logic    req_v,
    input  wr_req_t req,
    output logic    ready,
    output logic    commit_v,
    output wr_req_t commit
);
    localparam int CW = $clog2(LAT + 1);

    logic          pending;
    logic [CW-1:0] cnt;
    wr_req_t       held;

    assign ready    = !pending;
    assign commit   = held;
    assign commit_v = pending && slow_tick && (cnt == CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            cnt     <= '0;
            held    <= '0;
        end else if (!pending) begin
            if (req_v) begin
                pending <= 1'b1;
                cnt     <= CW'(LAT);
                held    <= req;
            end
        end else if (slow_tick) begin
            cnt <= cnt - CW'(1);
            if (cnt == CW'(1)) begin
                pending <= 1'b0;
            end
        end
    end

    AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
        req_v && ready |=> !ready); // R2
    AST_BUSY_DROPS_WRITE: assert property (@(posedge clk) disable iff (rst)
        req_v && !ready |=> $stable(held)); // R3
    AST_READY_AFTER_COMMIT: assert property (@(posedge clk) disable iff (rst)
        commit_v |=> ready); // R2
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              commit_v,
    input  wr_req_t           commit,
    input  logic              sec_tick,
    output ctrl_t             ctrl,
    output logic [RTC_DW-1:0] secs,
    output logic [RTC_DW-1:0] alarm,
    output logic [RTC_DW-1:0] scratch,
    output logic              hib_pulse
);
    logic  wr_ctrl, wr_secs, wr_alarm, wr_scr, wr_hib;
    logic  alarm_hit;
    ctrl_t ctrl_nxt;

    assign wr_ctrl  = commit_v && (commit.addr == OFF_CTRL);
    assign wr_secs  = commit_v && (commit.addr == OFF_SECS);
    assign wr_alarm = commit_v && (commit.addr == OFF_ALARM);
    assign wr_scr   = commit_v && (commit.addr == OFF_SCR);
    assign wr_hib   = commit_v && (commit.addr == OFF_HIB);

    assign alarm_hit = ctrl.ae && (secs == alarm);

    always_comb begin
        ctrl_nxt = ctrl;
        if (wr_ctrl) begin
            ctrl_nxt = merge_ctrl(ctrl, commit.data);
        end
        if (sec_tick) begin
            ctrl_nxt.hz = 1'b1;
        end
        if (alarm_hit) begin
            ctrl_nxt.af = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '0;
            secs      <= '0;
            alarm     <= '0;
            hib_pulse <= 1'b0;
        end else begin
            ctrl      <= ctrl_nxt;
            hib_pulse <= wr_hib && commit.data[0];
            if (wr_secs) begin
                secs <= commit.data;
            end else if (sec_tick) begin
                secs <= secs + RTC_DW'(1);
            end
            if (wr_alarm) begin
                alarm <= commit.data;
            end
        end
    end

    // scratchpad survives the block reset on purpose
    always_ff @(posedge clk) begin
        if (wr_scr) begin
            scratch <= commit.data;
        end
    end

    AST_HZ_FROM_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl.hz) |-> $past(sec_tick)); // R6
    AST_SEC_STEP: assert property (@(posedge clk) disable iff (rst)
        sec_tick && !wr_secs |=> secs == $past(secs) + 32'd1); // R6
    AST_SEC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !sec_tick && !wr_secs |=> $stable(secs)); // R6
    AST_AF_GATED: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl.af) |-> $past(ctrl.ae)); // R7
    AST_FLAG_KEPT: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl && commit.data[B_HZ] && ctrl.hz |=> ctrl.hz); // R5
    AST_HIB_SINGLE: assert property (@(posedge clk) disable iff (rst)
        hib_pulse |=> !hib_pulse); // R9
endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
    import rtc_pkg::*;
#(
    parameter int DIV    = 32768,
    parameter int WR_LAT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slow_tick,
    input  logic [RTC_AW-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [RTC_DW-1:0] bus_wdata,
    output logic [RTC_DW-1:0] bus_rdata,
    output logic              irq_o,
    output logic              hib_o
);
    wr_req_t           req, commit;
    logic              ready, commit_v, sec_tick;
    ctrl_t             ctrl;
    logic [RTC_DW-1:0] secs, alarm, scratch;

    assign req.addr = bus_addr;
    assign req.data = bus_wdata;

    rtc_wr_pipe #(.LAT(WR_LAT)) u_pipe (
        .clk(clk), .rst(rst), .slow_tick(slow_tick),
        .req_v(bus_wr), .req(req),
        .ready(ready), .commit_v(commit_v), .commit(commit)
    );

    rtc_prescaler #(.DIV(DIV)) u_pre (
        .clk(clk), .rst(rst), .run(ctrl.en),
        .slow_tick(slow_tick), .sec_tick(sec_tick)
    );

    rtc_regs u_regs (
        .clk(clk), .rst(rst),
        .commit_v(commit_v), .commit(commit), .sec_tick(sec_tick),
        .ctrl(ctrl), .secs(secs), .alarm(alarm),
        .scratch(scratch), .hib_pulse(hib_o)
    );

    always_comb begin
        case (bus_addr)
            OFF_CTRL:  bus_rdata = pack_ctrl(ctrl, ready);
            OFF_SECS:  bus_rdata = secs;
            OFF_ALARM: bus_rdata = alarm;
            OFF_SCR:   bus_rdata = scratch;
            default:   bus_rdata = '0;
        endcase
    end

    assign irq_o = (ctrl.hz && ctrl.hz_ie) || (ctrl.af && ctrl.af_ie);

    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (bus_addr != OFF_CTRL) || bus_rdata[B_HZ] || bus_rdata[B_AF]); // R8
endmodule

// File: tb/sec_rtc_test.sv
module sec_rtc_test;
    import rtc_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        slow_tick = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, hib_o;

    sec_rtc #(.DIV(4), .WR_LAT(2)) uut (
        .clk(clk), .rst(rst), .slow_tick(slow_tick),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o), .hib_o(hib_o)
    );

    always #5 clk = ~clk;

    logic st_div = 1'b0;
    always @(posedge clk) begin
        st_div    <= ~st_div;
        slow_tick <= st_div;
    end

    int hib_cnt = 0;
    always @(posedge clk) if (!rst && hib_o) hib_cnt <= hib_cnt + 1;

    typedef struct {
        int          kind;   // 0 read data, 1 irq, 2 hib pulse count
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    logic  mon_go = 1'b0;
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;

    always @(negedge clk) begin
        if (mon_go && q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            case (it.kind)
                0:       act = bus_rdata;
                1:       act = {31'b0, irq_o};
                default: act = 32'(hib_cnt);
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic push(input int k, input logic [5:0] a, input logic [31:0] e, input string t);
        item_t it;
        @(posedge clk); #1;
        bus_addr = a;
        it.kind = k; it.exp = e; it.tag = t;
        q.push_back(it);
        mon_go = 1'b1;
        @(negedge clk); #1;
        mon_go = 1'b0;
    endtask

    task automatic expect_rd(input logic [5:0] a, input logic [31:0] e, input string t);
        push(0, a, e, t);
    endtask

    task automatic expect_irq(input logic e, input string t);
        push(1, OFF_CTRL, {31'b0, e}, t);
    endtask

    task automatic expect_hib(input int e, input string t);
        push(2, OFF_CTRL, 32'(e), t);
    endtask

    task automatic wait_ready();
        @(negedge clk); #1;
        bus_addr = OFF_CTRL;
        #1;
        while (!bus_rdata[7]) begin
            @(negedge clk); #1;
        end
    endtask

    task automatic poke(input logic [5:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d, input bit finish_it);
        wait_ready();
        poke(a, d);
        if (finish_it) begin
            wait_ready();
            repeat (2) @(posedge clk);
            #1;
        end
    endtask

    task automatic read_secs(output logic [31:0] v);
        logic [31:0] a, b;
        @(negedge clk); #1;
        bus_addr = OFF_SECS;
        do begin
            @(negedge clk); a = bus_rdata;
            @(negedge clk); b = bus_rdata;
        end while (a != b);
        v = b;
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                checks++; errors++;
                $display("FAIL watchdog actual=%0d expected=<100000", cyc);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] s, s2;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        expect_rd(OFF_CTRL, 32'h80, "R1 ctrl after reset");
        expect_rd(OFF_SECS, 32'h0, "R1 seconds after reset");
        expect_irq(1'b0, "R1 irq after reset");
        expect_hib(0, "R1 no hibernate after reset");

        // R2 ready drops, value lands later
        wr(OFF_SECS, 32'd100, 0);
        expect_rd(OFF_CTRL, 32'h00, "R2 ready low while busy");
        wait_ready();
        expect_rd(OFF_SECS, 32'd100, "R2 seconds after commit");

        // R3 write while busy is dropped
        wr(OFF_SCR, 32'hA5A5_0001, 0);
        poke(OFF_SCR, 32'hDEAD_BEEF);
        wait_ready();
        expect_rd(OFF_SCR, 32'hA5A5_0001, "R3 busy write dropped");

        // R1 unmapped offset
        wr(6'h0C, 32'h1234, 1);
        expect_rd(6'h0C, 32'h0, "R1 unmapped reads zero");

        // R10 scratchpad persists through reset
        wr(OFF_SCR, 32'h1234_5678, 1);
        @(posedge clk); #1 rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        expect_rd(OFF_SCR, 32'h1234_5678, "R10 scratch kept over reset");
        expect_rd(OFF_SECS, 32'h0, "R1 seconds cleared by reset");

        // R7 alarm while counting
        wr(OFF_SECS, 32'd100, 1);
        wr(OFF_ALARM, 32'd102, 1);
        expect_rd(OFF_ALARM, 32'd102, "R4 alarm readback");
        wr(OFF_CTRL, 32'h0D, 1);
        do read_secs(s); while (s < 32'd103);
        expect_rd(OFF_CTRL, 32'hDD, "R7 alarm flag and R6 second flag");
        expect_irq(1'b1, "R8 alarm irq");

        // R5 flag semantics with counter stopped
        wr(OFF_CTRL, 32'h5C, 1);
        expect_rd(OFF_CTRL, 32'hDC, "R5 flags kept by writing ones");
        wr(OFF_CTRL, 32'h1C, 1);
        expect_rd(OFF_CTRL, 32'h9C, "R5 second flag cleared, alarm flag kept");
        expect_irq(1'b1, "R8 irq from alarm flag");
        wr(OFF_CTRL, 32'h0C, 1);
        expect_rd(OFF_CTRL, 32'h8C, "R5 alarm flag cleared");
        expect_irq(1'b0, "R8 irq low with no flags");

        // R6 disabled counter holds
        read_secs(s);
        repeat (40) @(posedge clk);
        read_secs(s2);
        if (s2 !== s) begin
            errors++;
            $display("FAIL R6 hold actual=%h expected=%h", s2, s);
        end
        checks++;

        // R8 one-second interrupt
        wr(OFF_CTRL, 32'h21, 1);
        @(negedge clk); #1 bus_addr = OFF_CTRL;
        #1;
        while (!bus_rdata[6]) begin @(negedge clk); #1; end
        expect_irq(1'b1, "R8 one-second irq");
        wr(OFF_CTRL, 32'h60, 1);
        expect_rd(OFF_CTRL, 32'hE0, "R4 counter stopped, flag and enable kept");
        wr(OFF_CTRL, 32'h00, 1);
        expect_rd(OFF_CTRL, 32'h80, "R5 all flags cleared");
        expect_irq(1'b0, "R8 irq cleared");

        // R7 alarm gated by enable
        wr(OFF_ALARM, 32'd500, 1);
        wr(OFF_SECS, 32'd500, 1);
        repeat (6) @(posedge clk);
        expect_rd(OFF_CTRL, 32'h80, "R7 no alarm flag with enable clear");
        wr(OFF_CTRL, 32'h04, 1);
        expect_rd(OFF_CTRL, 32'h94, "R7 alarm flag once enabled");

        // R9 hibernate
        wr(OFF_HIB, 32'h1, 1);
        expect_hib(1, "R9 one pulse on request");
        wr(OFF_HIB, 32'h0, 1);
        repeat (4) @(posedge clk);
        expect_hib(1, "R9 no pulse for zero");

        // R6 wrap, R11 write overrides count
        wr(OFF_SECS, 32'hFFFF_FFFF, 1);
        wr(OFF_CTRL, 32'h01, 1);
        do read_secs(s); while (s == 32'hFFFF_FFFF);
        if (s !== 32'h0) begin
            errors++;
            $display("FAIL R6 wrap actual=%h expected=%h", s, 32'h0);
        end
        checks++;
        wr(OFF_SECS, 32'd7000, 1);
        wr(OFF_CTRL, 32'h40, 1);
        read_secs(s);
        if (s < 32'd7000 || s > 32'd7002) begin
            errors++;
            $display("FAIL R11 seconds write actual=%0d expected=7000..7002", s);
        end
        checks++;
        expect_rd(OFF_CTRL, 32'hC0, "R6 second flag after wrap");

        repeat (3) @(posedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule